// File: doc/BRIEF.md
# Boot Signature Validator

This block decides, right after reset, whether the processor may start the user program held in flash. It walks the first flash page through a plain synchronous read port, one 32-bit word per cycle. It keeps a running modulo-2^32 sum of every word except the signature word, which sits at byte offset 0x14 and is held in a register of its own. When the last word has arrived, the signature is judged. It is accepted when it equals the fixed constant 0x27011970. It is also accepted when it equals the sum of all the other words of the page.

An accepted page pulses `run_user`. A rejected page pulses `enter_download`, which sends boot into the download path so that user code is never started. Either pulse comes together with `done`. The scan starts by itself after reset, and a synchronous `start` aborts any scan in progress and begins a new one from address 0.

The read port has no back-pressure. The block raises `mem_rd_en` with a byte address, and the memory must return that word on `mem_rd_data` in the very next cycle. A new address may follow in every cycle, so the memory side must accept one read per cycle and always answer with a latency of exactly one cycle. The verdict pins are plain one-cycle pulses with no handshake.

Top module: `boot_sig_check`

## Requirements
- R1: A scan issues exactly PAGE_BYTES/4 reads, one per cycle with no gaps, at byte addresses 0, 4, 8, ... PAGE_BYTES-4 in ascending order. The first read comes in the cycle after `start` is sampled.
- R2: While `rst_n` is low, `mem_rd_en`, `done`, `run_user` and `enter_download` are low. After reset is released, a scan starts without any `start` pulse, and its verdict appears PAGE_BYTES/4+2 clock edges after the release.
- R3: The page passes when the word at byte offset 0x14 (word index 5) equals 32'h27011970, whatever the other words hold.
- R4: The page passes when the word at byte offset 0x14 equals the modulo-2^32 sum of all other words of the page. This includes the all-zero page and sums that wrap past 2^32.
- R5: When the word at 0x14 matches neither the constant nor the sum, `enter_download` pulses and `run_user` stays low. A value one bit away from the constant, or one above the sum, is a failure.
- R6: `done` is high for exactly one cycle, PAGE_BYTES/4+1 clock edges after the edge that samples `start`. Exactly one of `run_user` and `enter_download` is high in that same cycle, and both are low in every other cycle.
- R7: A `start` during a scan discards it. That scan yields no verdict, the reads restart at address 0, and the next verdict depends only on the new pass over the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Synchronous restart of the scan |
| mem_rd_en | output | 1 | Read request to the flash page |
| mem_rd_addr | output | ADDR_W | Byte address of the requested word |
| mem_rd_data | input | 32 | Word returned one cycle after the request |
| done | output | 1 | One-cycle pulse when a verdict is ready |
| run_user | output | 1 | Pulse: signature accepted, start user code |
| enter_download | output | 1 | Pulse: signature rejected, take download path |

## Verification
The assertions check the address walk on every cycle. Each read follows the previous one by four bytes, and a restart always issues address 0 next. The same goes for the verdict pins: `done` is a single-cycle pulse, exactly one verdict goes with it, and no read is in flight at that point. Whether a particular page is accepted can only be shown by the bench, which sets up the memory image for each case. These cases cover the constant, a correct sum, wrapping and zero sums, and near misses. The bench alone also measures the exact verdict latency, the start after reset, and the effect of an aborted scan.

// File: rtl/boot_sig_pkg.sv
package boot_sig_pkg;
  localparam int unsigned WORD_W     = 32;
  localparam int unsigned WORD_BYTES = WORD_W / 8;
  localparam int unsigned BYTE_SEL_W = $clog2(WORD_BYTES);

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    V_NONE     = 2'd0,
    V_RUN      = 2'd1,
    V_DOWNLOAD = 2'd2
  } verdict_e;
endpackage

// File: rtl/bsv_fetch.sv
module bsv_fetch
  import boot_sig_pkg::*;
#(
  parameter int unsigned NWORDS = 128,
  parameter int unsigned IDX_W  = 7,
  parameter int unsigned ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rsp_valid,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic              rsp_last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NWORDS - 1);

  logic             boot_kick;
  logic             active;
  logic [IDX_W-1:0] idx;
  logic             go;

  // a restart comes from the pin or from the first cycle out of reset
  assign go = start | boot_kick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      boot_kick <= 1'b1;
      active    <= 1'b0;
      idx       <= '0;
      rsp_valid <= 1'b0;
      rsp_idx   <= '0;
      rsp_last  <= 1'b0;
    end else begin
      boot_kick <= 1'b0;
      if (go) begin
        active    <= 1'b1;
        idx       <= '0;
        rsp_valid <= 1'b0;
        rsp_last  <= 1'b0;
      end else begin
        rsp_valid <= active;
        rsp_idx   <= idx;
        rsp_last  <= active && (idx == LAST_IDX);
        if (active) begin
          if (idx == LAST_IDX) active <= 1'b0;
          else                 idx    <= idx + 1'b1;
        end
      end
    end
  end

  assign rd_en   = active;
  assign rd_addr = ADDR_W'({idx, {BYTE_SEL_W{1'b0}}});
endmodule

// File: rtl/bsv_accum.sv
module bsv_accum
  import boot_sig_pkg::*;
#(
  parameter int unsigned IDX_W   = 7,
  parameter int unsigned SIG_IDX = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             in_valid,
  input  logic [IDX_W-1:0] in_idx,
  input  word_t            in_data,
  output word_t            sum_next,
  output word_t            sig_next
);
  word_t sum_q;
  word_t sig_q;
  logic  is_sig;

  assign is_sig   = (in_idx == IDX_W'(SIG_IDX));
  assign sum_next = sum_q + ((in_valid && !is_sig) ? in_data : '0);
  assign sig_next = (in_valid && is_sig) ? in_data : sig_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_q <= '0;
      sig_q <= '0;
    end else if (clear) begin
      sum_q <= '0;
      sig_q <= '0;
    end else if (in_valid) begin
      sum_q <= sum_next;
      sig_q <= sig_next;
    end
  end
endmodule

// File: rtl/bsv_judge.sv
module bsv_judge
  import boot_sig_pkg::*;
#(
  parameter word_t MAGIC = 32'h2701_1970
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clear,
  input  logic  final_valid,
  input  word_t final_sum,
  input  word_t final_sig,
  output logic  done,
  output logic  run_user,
  output logic  enter_download
);
  verdict_e verdict_q;
  logic     accept;

  assign accept = (final_sig == MAGIC) || (final_sig == final_sum);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      verdict_q <= V_NONE;
    end else if (clear || !final_valid) begin
      verdict_q <= V_NONE;
    end else begin
      verdict_q <= accept ? V_RUN : V_DOWNLOAD;
    end
  end

  assign done           = (verdict_q != V_NONE);
  assign run_user       = (verdict_q == V_RUN);
  assign enter_download = (verdict_q == V_DOWNLOAD);
endmodule

// File: rtl/boot_sig_check.sv
module boot_sig_check
  import boot_sig_pkg::*;
#(
  parameter int unsigned PAGE_BYTES = 512,
  parameter int unsigned SIG_OFFSET = 32'h14,
  parameter word_t       MAGIC      = 32'h2701_1970,
  localparam int unsigned ADDR_W    = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              done,
  output logic              run_user,
  output logic              enter_download
);
  localparam int unsigned NWORDS  = PAGE_BYTES / WORD_BYTES;
  localparam int unsigned IDX_W   = $clog2(NWORDS);
  localparam int unsigned SIG_IDX = SIG_OFFSET / WORD_BYTES;

  logic             rsp_valid;
  logic [IDX_W-1:0] rsp_idx;
  logic             rsp_last;
  word_t            sum_next;
  word_t            sig_next;

  bsv_fetch #(.NWORDS(NWORDS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .rd_en     (mem_rd_en),
    .rd_addr   (mem_rd_addr),
    .rsp_valid (rsp_valid),
    .rsp_idx   (rsp_idx),
    .rsp_last  (rsp_last)
  );

  bsv_accum #(.IDX_W(IDX_W), .SIG_IDX(SIG_IDX)) u_accum (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (start),
    .in_valid (rsp_valid),
    .in_idx   (rsp_idx),
    .in_data  (mem_rd_data),
    .sum_next (sum_next),
    .sig_next (sig_next)
  );

  bsv_judge #(.MAGIC(MAGIC)) u_judge (
    .clk            (clk),
    .rst_n          (rst_n),
    .clear          (start),
    .final_valid    (rsp_valid && rsp_last),
    .final_sum      (sum_next),
    .final_sig      (sig_next),
    .done           (done),
    .run_user       (run_user),
    .enter_download (enter_download)
  );
endmodule

// File: rtl/bsv_checker.sv
module bsv_checker #(
  parameter int unsigned ADDR_W = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              done,
  input logic              run_user,
  input logic              enter_download
);
  a_r1_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_en && $past(mem_rd_en) && !$past(start))
      |-> (mem_rd_addr == $past(mem_rd_addr) + ADDR_W'(4)));

  a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start) |-> (mem_rd_en && mem_rd_addr == '0));

  a_r6_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (run_user ^ enter_download));

  a_r6_quiet_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> (!run_user && !enter_download));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r6_scan_over: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd_en);
endmodule

bind boot_sig_check bsv_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .start          (start),
  .mem_rd_en      (mem_rd_en),
  .mem_rd_addr    (mem_rd_addr),
  .done           (done),
  .run_user       (run_user),
  .enter_download (enter_download)
);

// File: tb/boot_sig_check_test.sv
`timescale 1ns/1ps
module boot_sig_check_test;
  localparam int unsigned PAGE_BYTES = 512;
  localparam int unsigned ADDR_W = $clog2(PAGE_BYTES);
  localparam int unsigned NWORDS = PAGE_BYTES / 4;
  localparam int unsigned SIGW   = 5;
  localparam logic [31:0] MAGIC  = 32'h2701_1970;

  // seed, mode, expected pass
  localparam int NVEC = 7;
  localparam logic [35:0] VEC [NVEC] = '{
    {32'h1234_5678, 3'd0, 1'b1},
    {32'hA5A5_0F0F, 3'd1, 1'b1},
    {32'h0BAD_F00D, 3'd2, 1'b0},
    {32'h2701_1970, 3'd3, 1'b0},
    {32'h0000_0000, 3'd4, 1'b1},
    {32'h0000_0000, 3'd5, 1'b1},
    {32'h0000_0000, 3'd6, 1'b0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic mem_rd_en;
  logic [ADDR_W-1:0] mem_rd_addr;
  logic [31:0] mem_rd_data;
  logic done, run_user, enter_download;

  logic [31:0] mem [NWORDS];
  int n_checks = 0;
  int n_fail = 0;
  int exp_addr = 0;
  int req_cnt = 0;

  always #5 clk = ~clk;

  boot_sig_check #(.PAGE_BYTES(PAGE_BYTES)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
    .done(done), .run_user(run_user), .enter_download(enter_download)
  );

  always @(posedge clk) if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr[ADDR_W-1:2]];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // address walk and quiet verdict pins during a scan (R1, R6)
  always @(negedge clk) if (rst_n) begin
    if (mem_rd_en) begin
      check(mem_rd_addr == ADDR_W'(exp_addr), "R1", "read address", 32'(mem_rd_addr), 32'(exp_addr));
      check(!run_user && !enter_download, "R6", "verdict during scan",
            {30'd0, run_user, enter_download}, 32'd0);
      exp_addr += 4;
      req_cnt++;
    end
    if (done) check(req_cnt == NWORDS, "R1", "reads per scan", 32'(req_cnt), 32'(NWORDS));
    if (start) begin
      exp_addr = 0;
      req_cnt = 0;
    end
  end

  task automatic fill(input logic [31:0] seed, input logic [2:0] mode);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < NWORDS; i++) begin
      case (mode)
        3'd4: mem[i] = 32'h0;
        3'd5, 3'd6: mem[i] = 32'hFFFF_FFFF;
        default: mem[i] = seed ^ (32'(i) * 32'h9E37_79B9);
      endcase
      if (i != SIGW) s = s + mem[i];
    end
    case (mode)
      3'd0: mem[SIGW] = MAGIC;
      3'd1: mem[SIGW] = s;
      3'd2: mem[SIGW] = s + 32'd1;
      3'd3: mem[SIGW] = MAGIC ^ 32'h0000_0100;
      3'd4: mem[SIGW] = 32'h0;
      3'd5: mem[SIGW] = s;
      default: mem[SIGW] = 32'hFFFF_FFFF;
    endcase
  endtask

  task automatic wait_verdict(output int cnt);
    cnt = 0;
    while (!done && cnt < 3 * NWORDS) begin
      @(posedge clk); #1;
      cnt++;
    end
  endtask

  task automatic judge(input bit exp_pass, input string req);
    check(done, req, "done seen", 32'(done), 32'd1);
    check(run_user == exp_pass && enter_download == !exp_pass, req, "verdict",
          {30'd0, run_user, enter_download}, {30'd0, exp_pass, !exp_pass});
    @(posedge clk); #1;
    check(!done && !run_user && !enter_download, "R6", "pulse width",
          {29'd0, done, run_user, enter_download}, 32'd0);
  endtask

  task automatic run_case(input bit exp_pass, input string req);
    int cnt;
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    wait_verdict(cnt);
    check(cnt == NWORDS + 1, "R6", "verdict latency", 32'(cnt), 32'(NWORDS + 1));
    judge(exp_pass, req);
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    int cnt;
    bit seen;
    string tag;
    fill(32'h0, 3'd0);
    // R2: quiet while in reset
    repeat (3) @(posedge clk);
    #1;
    check(!mem_rd_en && !done && !run_user && !enter_download, "R2", "reset outputs",
          {28'd0, mem_rd_en, done, run_user, enter_download}, 32'd0);
    @(posedge clk); #1 rst_n = 1'b1;
    wait_verdict(cnt);
    check(cnt == NWORDS + 2, "R2", "auto scan latency", 32'(cnt), 32'(NWORDS + 2));
    judge(1'b1, "R2");

    // table of page images
    for (int v = 0; v < NVEC; v++) begin
      fill(VEC[v][35:4], VEC[v][3:1]);
      case (VEC[v][3:1])
        3'd0: tag = "R3";
        3'd1, 3'd4, 3'd5: tag = "R4";
        default: tag = "R5";
      endcase
      run_case(VEC[v][0], tag);
    end

    // R7: abort a scan of a bad page, then rescan a good one
    fill(32'h5555_AAAA, 3'd2);
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #1;
      seen |= done;
    end
    check(!seen, "R7", "no verdict before abort", 32'(seen), 32'd0);
    fill(32'h5555_AAAA, 3'd1);
    run_case(1'b1, "R7");

    // R7: abort a good page, rescan with a bad one
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
    repeat (NWORDS - 3) @(posedge clk);
    #1;
    check(!done, "R7", "no verdict mid scan", 32'(done), 32'd0);
    fill(32'h5555_AAAA, 3'd2);
    run_case(1'b0, "R7");

    // R6: pins stay low once the verdict is over
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(posedge clk); #1;
      seen |= done | run_user | enter_download | mem_rd_en;
    end
    check(!seen, "R6", "idle after verdict", 32'(seen), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule